// File: doc/BRIEF.md
# Digital Quadrature Upconverter with Fixed Carrier Sequences

This block sits in a transmit datapath after the interpolation filters. It takes a complex baseband stream, given as an I lane and a Q lane qualified by a valid strobe, and moves it up in frequency by one half, one quarter or one eighth of the output sample rate. It can also pass the stream through unchanged. The shift uses short carrier sequences of 0, ±1 and ±√2/2, read from an eight-entry cosine table. No numerically controlled oscillator is involved.

At the two slower rates the block works in one of two ways. In real mode both lanes are scaled by the same carrier sequence. In complex mode the pair is multiplied by a cosine/sine carrier, which keeps one sideband. The sign of the sine term chooses which sideband that is. Results are held in one register stage and clipped to the 16-bit two's-complement range. A complex product can grow by about 3 dB, so upstream stages are expected to leave that much headroom. Any excess is clipped, never wrapped.

The carrier phase restarts whenever the rate selection changes. It moves on only when a valid sample is taken, so idle gaps in the stream do not move the carrier.

Top module: `quad_upconv`

## Requirements
- R1: While reset is asserted, out_valid is 0 and out_re and out_im are 0. The carrier phase and the remembered rate return to phase 0 and rate 00.
- R2: out_valid is in_valid delayed by one clock. A sample taken at an edge appears at the outputs right after that edge. While in_valid is 0, out_re and out_im hold their last values.
- R3: With rate_sel = 00 (bypass), out_re equals in_i and out_im equals in_q. cplx_en and lower_sb have no effect.
- R4: With rate_sel = 01 (half rate), both lanes are multiplied by the repeating sequence +1, −1, starting with +1 at phase 0. The result is the same in real and complex mode.
- R5: With rate_sel = 10 (quarter rate) and cplx_en = 0, both lanes are multiplied by the repeating sequence 0, +1, 0, −1, starting at phase 0.
- R6: With rate_sel = 11 (eighth rate) and cplx_en = 0, both lanes are multiplied by the repeating sequence 0, h, +1, h, 0, −h, −1, −h, where h stands for √2/2.
- R7: With cplx_en = 1 at rates 01, 10 and 11: out_re = I·c − σ·Q·s and out_im = σ·I·s + Q·c. The cosine c at phase n is cos(n·k·45°), with k = 4, 2 or 1 for rates 01, 10 and 11. The sine s lags c by a quarter period. σ is +1 when lower_sb = 0 (upper sideband kept) and −1 when lower_sb = 1 (lower sideband kept).
- R8: A product with ±h is ±floor((x·23170 + 16384) / 32768), computed with the sign of x.
- R9: A result above 32767 is output as 32767, and a result below −32768 is output as −32768.
- R10: When rate_sel differs from the rate in use at the previous clock, the phase restarts at 0. The restart applies even when no sample is valid. A sample taken in that cycle uses phase 0.
- R11: The carrier phase advances by one only for each sample taken with in_valid = 1. Idle cycles leave the carrier sequence where it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | Carrier rate: 00 bypass, 01 half, 10 quarter, 11 eighth |
| cplx_en | input | 1 | 1 selects complex (single-sideband) mode |
| lower_sb | input | 1 | In complex mode, 1 keeps the lower sideband |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | In-phase sample, two's complement |
| in_q | input | 16 | Quadrature sample, two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_re | output | 16 | Real output lane, two's complement |
| out_im | output | 16 | Imaginary output lane, two's complement |

## Verification
The hardest case to reach from the ports is a phase restart caused by a rate change while no sample is valid. It leaves no trace on the outputs until the next sample. The stimulus reaches it in three steps. First it leaves the phase at a point where continuing without a restart would give the opposite sign. Next it toggles rate_sel through another value over idle cycles. Then it sends one sample and checks its sign. The same run also carries the phase across several rate switches and complex-mode samples, and it drives values at the ±h and ±1 extremes to reach clipping in both real and complex mode.

// File: rtl/qmod_pkg.sv
package qmod_pkg;

  typedef enum logic [1:0] {
    RATE_NONE    = 2'd0,
    RATE_HALF    = 2'd1,
    RATE_QUARTER = 2'd2,
    RATE_EIGHTH  = 2'd3
  } rate_e;

  typedef enum logic [2:0] {
    CF_ZERO = 3'd0,
    CF_POS1 = 3'd1,
    CF_NEG1 = 3'd2,
    CF_POSH = 3'd3,
    CF_NEGH = 3'd4
  } coef_e;

  function automatic coef_e coef_negate(input coef_e c);
    case (c)
      CF_POS1: return CF_NEG1;
      CF_NEG1: return CF_POS1;
      CF_POSH: return CF_NEGH;
      CF_NEGH: return CF_POSH;
      default: return CF_ZERO;
    endcase
  endfunction

  // Cosine at multiples of 45 degrees.
  function automatic coef_e cos_octant(input logic [2:0] idx);
    case (idx)
      3'd0:    return CF_POS1;
      3'd1:    return CF_POSH;
      3'd2:    return CF_ZERO;
      3'd3:    return CF_NEGH;
      3'd4:    return CF_NEG1;
      3'd5:    return CF_NEGH;
      3'd6:    return CF_ZERO;
      default: return CF_POSH;
    endcase
  endfunction

endpackage

// File: rtl/qmod_phase.sv
module qmod_phase
  import qmod_pkg::*;
#(
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  rate_e              rate,
  input  logic               adv,
  output logic [PHASE_W-1:0] phase_now
);

  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] phase_d;
  rate_e              rate_q;
  logic               restart;
  logic               phase_en;

  always_comb begin
    restart   = (rate != rate_q);
    phase_now = restart ? '0 : phase_q;
    phase_d   = adv ? phase_now + PHASE_W'(1) : phase_now;
    phase_en  = adv || restart;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      rate_q  <= RATE_NONE;
    end else begin
      if (phase_en) phase_q <= phase_d;
      if (restart)  rate_q  <= rate;
    end
  end

  // R10: a restart together with a sample leaves the phase at one
  p_restart_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && adv) |=> (phase_q == PHASE_W'(1)));

  // R10: an idle restart leaves the phase at zero
  p_restart_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !adv) |=> (phase_q == '0));

  // R11: steady rate, one step per taken sample
  p_advance_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && adv) |=> (phase_q == $past(phase_q) + PHASE_W'(1)));

  // R11: idle cycles do not move the carrier
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !adv) |=> $stable(phase_q));

endmodule

// File: rtl/qmod_carrier.sv
module qmod_carrier
  import qmod_pkg::*;
#(
  parameter int PHASE_W = 3
) (
  input  rate_e              rate,
  input  logic [PHASE_W-1:0] phase,
  input  logic               cplx_en,
  input  logic               lower_sb,
  output coef_e              k_re_i,
  output coef_e              k_re_q,
  output coef_e              k_im_i,
  output coef_e              k_im_q
);

  localparam logic [2:0] QUARTER_TURN = 3'd2;

  logic [2:0] cos_idx;
  logic [2:0] sin_idx;
  coef_e      cos_c;
  coef_e      sin_c;
  coef_e      sin_sb;
  coef_e      real_c;

  always_comb begin
    case (rate)
      RATE_HALF:    cos_idx = {phase[0], 2'b00};
      RATE_QUARTER: cos_idx = {phase[1:0], 1'b0};
      RATE_EIGHTH:  cos_idx = phase[2:0];
      default:      cos_idx = 3'd0;
    endcase
    sin_idx = cos_idx - QUARTER_TURN;
    cos_c   = cos_octant(cos_idx);
    sin_c   = cos_octant(sin_idx);
    sin_sb  = lower_sb ? coef_negate(sin_c) : sin_c;
    real_c  = (rate == RATE_HALF) ? cos_c : sin_c;

    if (rate == RATE_NONE) begin
      k_re_i = CF_POS1;
      k_re_q = CF_ZERO;
      k_im_i = CF_ZERO;
      k_im_q = CF_POS1;
    end else if (cplx_en) begin
      k_re_i = cos_c;
      k_re_q = coef_negate(sin_sb);
      k_im_i = sin_sb;
      k_im_q = cos_c;
    end else begin
      k_re_i = real_c;
      k_re_q = CF_ZERO;
      k_im_i = CF_ZERO;
      k_im_q = real_c;
    end
  end

endmodule

// File: rtl/qmod_lane.sv
module qmod_lane
  import qmod_pkg::*;
#(
  parameter int DW       = 16,
  parameter int HALF_VAL = 23170
) (
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] x_q,
  input  coef_e                k_i,
  input  coef_e                k_q,
  output logic signed [DW-1:0] y
);

  localparam int EW = DW + 2;
  localparam int PW = 2 * DW + 2;
  localparam logic signed [PW-1:0] HALF_W = PW'(HALF_VAL);
  localparam logic signed [PW-1:0] RND_W  = PW'(1) <<< (DW - 2);
  localparam logic signed [EW-1:0] MAX_E  = EW'((2 ** (DW - 1)) - 1);
  localparam logic signed [EW-1:0] MIN_E  = -EW'(2 ** (DW - 1));

  function automatic logic signed [EW-1:0] scale(input logic signed [DW-1:0] x,
                                                input coef_e c);
    logic signed [EW-1:0] xe;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd;
    xe   = EW'(x);
    prod = PW'(x) * HALF_W;
    rnd  = (prod + RND_W) >>> (DW - 1);
    case (c)
      CF_POS1: return xe;
      CF_NEG1: return -xe;
      CF_POSH: return rnd[EW-1:0];
      CF_NEGH: return -rnd[EW-1:0];
      default: return '0;
    endcase
  endfunction

  logic signed [EW-1:0] sum;

  always_comb begin
    sum = scale(x_i, k_i) + scale(x_q, k_q);
    if (sum > MAX_E)      y = MAX_E[DW-1:0];
    else if (sum < MIN_E) y = MIN_E[DW-1:0];
    else                  y = sum[DW-1:0];
  end

endmodule

// File: rtl/quad_upconv.sv
module quad_upconv
  import qmod_pkg::*;
#(
  parameter int DW       = 16,
  parameter int HALF_VAL = 23170
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           rate_sel,
  input  logic                 cplx_en,
  input  logic                 lower_sb,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im
);

  localparam int PHASE_W = 3;
  localparam int LANES   = 2;

  rate_e               rate;
  logic [PHASE_W-1:0]  phase;
  coef_e               k_re_i, k_re_q, k_im_i, k_im_q;
  coef_e               k_a [LANES];
  coef_e               k_b [LANES];
  logic signed [DW-1:0] lane_y [LANES];

  logic                 valid_q, valid_d;
  logic signed [DW-1:0] re_q, re_d, im_q, im_d;

  assign rate = rate_e'(rate_sel);

  qmod_phase #(.PHASE_W(PHASE_W)) i_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate      (rate),
    .adv       (in_valid),
    .phase_now (phase)
  );

  qmod_carrier #(.PHASE_W(PHASE_W)) i_carrier (
    .rate     (rate),
    .phase    (phase),
    .cplx_en  (cplx_en),
    .lower_sb (lower_sb),
    .k_re_i   (k_re_i),
    .k_re_q   (k_re_q),
    .k_im_i   (k_im_i),
    .k_im_q   (k_im_q)
  );

  assign k_a[0] = k_re_i;
  assign k_b[0] = k_re_q;
  assign k_a[1] = k_im_i;
  assign k_b[1] = k_im_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    qmod_lane #(.DW(DW), .HALF_VAL(HALF_VAL)) i_lane (
      .x_i (in_i),
      .x_q (in_q),
      .k_i (k_a[g]),
      .k_q (k_b[g]),
      .y   (lane_y[g])
    );
  end

  always_comb begin
    valid_d = in_valid;
    re_d    = in_valid ? lane_y[0] : re_q;
    im_d    = in_valid ? lane_y[1] : im_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      re_q    <= '0;
      im_q    <= '0;
    end else begin
      valid_q <= valid_d;
      if (in_valid) begin
        re_q <= re_d;
        im_q <= im_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_re    = re_q;
  assign out_im    = im_q;

  // R2: strobe is carried one clock
  p_valid_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R2: outputs hold through idle cycles
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_re) && $stable(out_im)));

  // R3: bypass passes samples unchanged
  p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rate_sel == 2'd0) |=>
      (out_re == $past(in_i) && out_im == $past(in_q)));

  // R4: half rate only ever passes or negates the in-phase sample
  p_half_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rate_sel == 2'd1 && in_i != {1'b1, {(DW-1){1'b0}}}) |=>
      (out_re == $past(in_i) || out_re == -$past(in_i)));

endmodule

// File: tb/test_quad_upconv.sv
`timescale 1ns/1ps
module test_quad_upconv;

  localparam int DW = 16;

  typedef struct packed {
    logic [1:0]           rate;
    logic                 cplx;
    logic                 lsb;
    logic signed [DW-1:0] i;
    logic signed [DW-1:0] q;
    logic signed [DW-1:0] re;
    logic signed [DW-1:0] im;
  } vec_t;

  localparam int NV = 20;
  // Applied back to back with in_valid high, right after reset.
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 1'b0, 16'sd1000,  -16'sd2000,  16'sd1000,  -16'sd2000},  // R3
    '{2'd1, 1'b0, 1'b0, 16'sd300,   16'sd400,    16'sd300,   16'sd400},    // R4 R10 ph0
    '{2'd1, 1'b0, 1'b0, 16'sd300,   16'sd400,    -16'sd300,  -16'sd400},   // R4 ph1
    '{2'd1, 1'b0, 1'b0, 16'h8000,   16'sd5,      16'h8000,   16'sd5},      // R4 ph2
    '{2'd1, 1'b0, 1'b0, 16'h8000,   16'sd5,      16'sd32767, -16'sd5},     // R9 ph3
    '{2'd2, 1'b0, 1'b0, 16'sd1000,  -16'sd1000,  16'sd0,     16'sd0},      // R5 ph0
    '{2'd2, 1'b0, 1'b0, 16'sd1000,  -16'sd1000,  16'sd1000,  -16'sd1000},  // R5 ph1
    '{2'd2, 1'b0, 1'b0, 16'sd1000,  -16'sd1000,  16'sd0,     16'sd0},      // R5 ph2
    '{2'd2, 1'b0, 1'b0, 16'sd1000,  -16'sd1000,  -16'sd1000, 16'sd1000},   // R5 ph3
    '{2'd3, 1'b0, 1'b0, 16'sd32767, 16'h8000,    16'sd0,     16'sd0},      // R6 ph0
    '{2'd3, 1'b0, 1'b0, 16'sd32767, 16'h8000,    16'sd23169, -16'sd23170}, // R6 R8 ph1
    '{2'd3, 1'b0, 1'b0, 16'sd32767, 16'h8000,    16'sd32767, 16'h8000},    // R6 ph2
    '{2'd3, 1'b1, 1'b0, 16'sd10000, 16'sd0,      -16'sd7071, 16'sd7071},   // R7 R8 ph3
    '{2'd3, 1'b1, 1'b1, 16'sd100,   16'sd200,    -16'sd100,  -16'sd200},   // R7 ph4
    '{2'd2, 1'b1, 1'b0, 16'sd500,   16'sd700,    16'sd500,   16'sd700},    // R7 ph0
    '{2'd2, 1'b1, 1'b0, 16'sd500,   16'sd700,    -16'sd700,  16'sd500},    // R7 upper ph1
    '{2'd2, 1'b1, 1'b0, 16'sd500,   16'sd700,    -16'sd500,  -16'sd700},   // R7 ph2
    '{2'd2, 1'b1, 1'b1, 16'sd500,   16'sd700,    -16'sd700,  16'sd500},    // R7 lower ph3
    '{2'd3, 1'b1, 1'b0, 16'sd30000, -16'sd30000, 16'sd30000, -16'sd30000}, // R7 ph0
    '{2'd3, 1'b1, 1'b0, 16'sd30000, -16'sd30000, 16'sd32767, 16'sd0}       // R9 complex ph1
  };

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [1:0]           rate_sel;
  logic                 cplx_en, lower_sb, in_valid;
  logic signed [DW-1:0] in_i, in_q;
  logic                 out_valid;
  logic signed [DW-1:0] out_re, out_im;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  quad_upconv i_quad_upconv (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_sel  (rate_sel),
    .cplx_en   (cplx_en),
    .lower_sb  (lower_sb),
    .in_valid  (in_valid),
    .in_i      (in_i),
    .in_q      (in_q),
    .out_valid (out_valid),
    .out_re    (out_re),
    .out_im    (out_im)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] r, input logic c, input logic l,
                      input logic v, input int i, input int q);
    @(negedge clk);
    rate_sel = r; cplx_en = c; lower_sb = l; in_valid = v;
    in_i = DW'(i); in_q = DW'(q);
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rate_sel = 2'd0; cplx_en = 1'b0; lower_sb = 1'b0;
    in_valid = 1'b0; in_i = '0; in_q = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset out_valid", int'(out_valid), 0);
    chk("R1 reset out_re", int'(out_re), 0);
    chk("R1 reset out_im", int'(out_im), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int n = 0; n < NV; n++) begin
      step(VEC[n].rate, VEC[n].cplx, VEC[n].lsb, 1'b1,
           int'(VEC[n].i), int'(VEC[n].q));
      chk($sformatf("R2 vec%0d out_valid", n), int'(out_valid), 1);
      chk($sformatf("R3-R9 vec%0d re", n), int'(out_re), int'(VEC[n].re));
      chk($sformatf("R3-R9 vec%0d im", n), int'(out_im), int'(VEC[n].im));
    end

    // R2 R11: idle cycles hold outputs and leave the phase alone
    step(2'd1, 1'b0, 1'b0, 1'b1, 50, 60);
    chk("R10 half restart re", int'(out_re), 50);
    for (int k = 0; k < 3; k++) begin
      step(2'd1, 1'b0, 1'b0, 1'b0, 999, -999);
      chk("R2 idle out_valid", int'(out_valid), 0);
      chk("R2 idle hold re", int'(out_re), 50);
      chk("R2 idle hold im", int'(out_im), 60);
    end
    step(2'd1, 1'b0, 1'b0, 1'b1, 50, 60);
    chk("R11 phase1 after gap re", int'(out_re), -50);
    chk("R11 phase1 after gap im", int'(out_im), -60);
    step(2'd1, 1'b0, 1'b0, 1'b1, 50, 60);
    chk("R11 phase2 re", int'(out_re), 50);

    // R10: rate toggled while idle restarts the phase (else phase3 gives -70)
    step(2'd2, 1'b0, 1'b0, 1'b0, 0, 0);
    step(2'd1, 1'b0, 1'b0, 1'b0, 0, 0);
    step(2'd1, 1'b0, 1'b0, 1'b1, 70, 80);
    chk("R10 idle restart re", int'(out_re), 70);
    chk("R10 idle restart im", int'(out_im), 80);

    // R3: bypass ignores complex and sideband controls
    step(2'd0, 1'b1, 1'b1, 1'b1, 7, -9);
    chk("R3 bypass cplx re", int'(out_re), 7);
    chk("R3 bypass cplx im", int'(out_im), -9);

    // R1: reset in mid-run clears the outputs at once
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 midrun out_valid", int'(out_valid), 0);
    chk("R1 midrun out_re", int'(out_re), 0);
    chk("R1 midrun out_im", int'(out_im), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: phase restored to 0 at rate 00; first half-rate sample gets +1
    step(2'd1, 1'b0, 1'b0, 1'b1, 123, 45);
    chk("R1 phase after reset re", int'(out_re), 123);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule